// File: doc/BRIEF.md
# Latched-Input Serial-Out Shift Register

This block turns a parallel word into a serial bit stream for an SPI-style read port. It has two registers. A holding latch captures the parallel input word when a capture strobe arrives. A separate shift chain either copies a word or shifts serial data toward its last stage, and that last stage is the serial output. The capture strobe and the shift strobe are independent. A new word can therefore be parked in the latch while the previous word is still leaving the chain.

Each strobe is a single-cycle enable pulse, synchronous to one system clock. A mode input picks the chain's behaviour. In load mode the chain follows the latch, or takes the parallel inputs directly when a capture happens in the same cycle. In shift mode each shift strobe moves every stage one place toward the output and enters the serial input at the first stage. The three-state serial output appears as a data bit plus a drive-valid flag, and an active-low enable controls the flag.

Top module: `latched_piso`

## Requirements
- R1: A synchronous active-high reset clears both the holding latch and the shift chain to zero. After reset `ser_out` is 0, and one load-mode cycle without a capture still leaves `ser_out` at 0.
- R2: A clock edge with `cap_stb` high stores `par_in` in the holding latch, in either mode.
- R3: With `shift_mode` = 0 (load) and `cap_stb` low, the chain takes the latch contents at the clock edge. `ser_in` and `shf_stb` have no effect.
- R4: With `shift_mode` = 0 and `cap_stb` high, the chain takes `par_in` at the same edge that writes the latch.
- R5: With `shift_mode` = 1 (shift) and `shf_stb` high, bit 0 (stage A) takes `ser_in` and bit i takes the old bit i-1, so the old bit W-2 becomes the new output.
- R6: With `shift_mode` = 1 and both strobes high, the latch captures `par_in` and the chain shifts in the same edge, and neither action alters the other.
- R7: With `shift_mode` = 1 and `shf_stb` low, the chain keeps its contents. With `cap_stb` low the latch also keeps its contents.
- R8: `ser_drive` is the inverse of `oe_n` in the same cycle. `oe_n` has no effect on the latch or the chain.
- R9: `ser_out` always equals the chain's last stage, bit W-1 (stage H), whatever the value of `ser_drive`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | WIDTH | Parallel data word |
| cap_stb | input | 1 | One-cycle strobe that captures `par_in` in the latch |
| shf_stb | input | 1 | One-cycle shift strobe, used in shift mode |
| shift_mode | input | 1 | 1 = shift serially, 0 = load the chain from the latch |
| ser_in | input | 1 | Serial data entering stage A |
| oe_n | input | 1 | Output enable, active low |
| ser_out | output | 1 | Last-stage data bit |
| ser_drive | output | 1 | High when the serial output is driven |

## Verification
In shift mode, a capture and a shift can fall on the same edge. In load mode, a capture and the chain load can also fall on the same edge, and then the chain must take the new word rather than the stale latch value. The sweep drives every combination of mode, both strobes, serial bit and enable many times, each with a fresh random word, so both coincidences occur often. It also drives directed sequences that put a known word in the chain and then shift while capturing a different word. Each coincident cycle is judged by the bench's model. Later load-mode copies show whether the latch took the new word, and the following shift-out bits show whether the chain was left undisturbed.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    parameter int unsigned LSR_WIDTH = 8;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } chain_mode_e;

    typedef struct packed {
        chain_mode_e mode;
        logic        cap;
        logic        shf;
        logic        sin;
    } chain_ctrl_t;

    function automatic chain_ctrl_t pack_ctrl(logic mode_bit, logic cap, logic shf, logic sin);
        chain_ctrl_t c;
        c.mode = chain_mode_e'(mode_bit);
        c.cap  = cap;
        c.shf  = shf;
        c.sin  = sin;
        return c;
    endfunction

endpackage

// File: rtl/hold_latch.sv
module hold_latch #(
    parameter int unsigned WIDTH = lsr_pkg::LSR_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (cap)
            q <= d;
    end

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        cap |=> (q == $past(d)));

    a_r7_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(q));

endmodule

// File: rtl/stage_chain.sv
module stage_chain
    import lsr_pkg::*;
#(
    parameter int unsigned WIDTH = LSR_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  chain_ctrl_t      ctrl,
    input  logic [WIDTH-1:0] lat,
    input  logic [WIDTH-1:0] par,
    output logic [WIDTH-1:0] q
);

    localparam int unsigned LAST = WIDTH - 1;

    logic [WIDTH-1:0] nxt;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic prev;
        if (i == 0) begin : g_first
            assign prev = ctrl.sin;
        end else begin : g_inner
            assign prev = q[i-1];
        end
        always_comb begin
            if (ctrl.mode == MODE_LOAD)
                nxt[i] = ctrl.cap ? par[i] : lat[i];
            else if (ctrl.shf)
                nxt[i] = prev;
            else
                nxt[i] = q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end

    a_r3_copy_latch: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_LOAD && !ctrl.cap) |=> (q == $past(lat)));

    a_r4_direct_load: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_LOAD && ctrl.cap) |=> (q == $past(par)));

    a_r5_shift_step: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_SHIFT && ctrl.shf) |=>
            (q[LAST:1] == $past(q[LAST-1:0]) && q[0] == $past(ctrl.sin)));

    a_r7_chain_hold: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_SHIFT && !ctrl.shf) |=> $stable(q));

endmodule

// File: rtl/latched_piso.sv
module latched_piso
    import lsr_pkg::*;
#(
    parameter int unsigned WIDTH = LSR_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] par_in,
    input  logic             cap_stb,
    input  logic             shf_stb,
    input  logic             shift_mode,
    input  logic             ser_in,
    input  logic             oe_n,
    output logic             ser_out,
    output logic             ser_drive
);

    localparam int unsigned LAST = WIDTH - 1;

    chain_ctrl_t      ctrl;
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] chain_q;

    assign ctrl = pack_ctrl(shift_mode, cap_stb, shf_stb, ser_in);

    hold_latch #(.WIDTH(WIDTH)) u_latch (
        .clk (clk),
        .rst (rst),
        .cap (cap_stb),
        .d   (par_in),
        .q   (lat_q)
    );

    stage_chain #(.WIDTH(WIDTH)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .lat  (lat_q),
        .par  (par_in),
        .q    (chain_q)
    );

    assign ser_out   = chain_q[LAST];
    assign ser_drive = ~oe_n;

    a_r1_reset_out: assert property (@(posedge clk)
        rst |=> (ser_out == 1'b0));

    a_r8_drive_flag: assert property (@(posedge clk) disable iff (rst)
        ser_drive != oe_n);

endmodule

// File: tb/latched_piso_tb.sv
module latched_piso_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] par_in = '0;
    logic         cap_stb = 1'b0;
    logic         shf_stb = 1'b0;
    logic         shift_mode = 1'b0;
    logic         ser_in = 1'b0;
    logic         oe_n = 1'b1;
    logic         ser_out;
    logic         ser_drive;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [W-1:0] m_lat = '0;
    logic [W-1:0] m_sr  = '0;

    always #5 clk = ~clk;

    latched_piso #(.WIDTH(W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .par_in     (par_in),
        .cap_stb    (cap_stb),
        .shf_stb    (shf_stb),
        .shift_mode (shift_mode),
        .ser_in     (ser_in),
        .oe_n       (oe_n),
        .ser_out    (ser_out),
        .ser_drive  (ser_drive)
    );

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_for(logic m, logic c, logic s);
        if (!m) return c ? "R4" : "R3";
        if (c && s) return "R6";
        if (s) return "R5";
        if (c) return "R2";
        return "R7";
    endfunction

    task automatic step(logic m, logic c, logic s, logic si, logic oen, logic [W-1:0] p);
        string t;
        @(negedge clk);
        shift_mode = m; cap_stb = c; shf_stb = s; ser_in = si; oe_n = oen; par_in = p;
        #1;
        check_bit("R8", ser_drive, ~oen);
        @(posedge clk);
        if (!m)      m_sr = c ? p : m_lat;
        else if (s)  m_sr = {m_sr[W-2:0], si};
        if (c)       m_lat = p;
        #1;
        t = tag_for(m, c, s);
        check_bit({t, "/R9"}, ser_out, m_sr[W-1]);
    endtask

    task automatic drain(logic oen);
        for (int k = 0; k < W; k++) step(1'b1, 1'b0, 1'b1, 1'b0, oen, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_bit("R1", ser_out, 1'b0);
        // R1: latch is zero too, so a load-mode copy keeps the output at 0
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF);
        check_bit("R1", ser_out, 1'b0);

        // R4 then R6: load a word, then capture a new word while shifting
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C);
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'hA5);
        drain(1'b0);
        // R3: copy the captured word (ser_in and shf_stb ignored)
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
        // R8: shift out with output disabled, contents still intact
        drain(1'b1);
        // R7: hold with no strobes
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h81);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b0, 1'b1, k[0], 8'h7E);
        drain(1'b0);

        // near-exhaustive control sweep with random words
        for (int rep = 0; rep < 80; rep++) begin
            for (int c = 0; c < 32; c++) begin
                step(c[4], c[3], c[2], c[1], c[0], W'($urandom));
            end
            if (rep % 8 == 0) drain(rep[4]);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule